// File: doc/BRIEF.md
# Shared Tag-Line Broadcast Controller

This block sits between the issue stage of an out-of-order scheduler and its wakeup array. Functional units are grouped in pairs, and each pair owns one set of result-tag broadcast lines instead of two. This halves the number of tag buses that cross the instruction window while the issue width stays the same. Each cycle the controller looks at the tags produced by both units of a pair and drives one of them onto the shared lines. The other tag is parked in that unit's hold register and goes out in a later cycle.

A parked tag raises a per-unit hold indicator. The issue arbiters use this indicator to keep any new tag-producing instruction away from that unit until the parked tag has gone out. Instructions that produce no register tag, such as branches and stores, may still issue to a unit whose indicator is set. They do not disturb the parked tag. A parked tag always wins the shared lines over a fresh tag, so it waits exactly one extra cycle. Units 2p and 2p+1 form pair p.

Top module: `tagline_share_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every broadcast valid bit and every hold indicator. They read zero in the cycle after reset is sampled.
- R2: With no parked tag in a pair, a single tag-producing issue (iss_vld=1, iss_wr_tag=1) in that pair appears on the pair's broadcast lines in the next cycle, with bc_vld high.
- R3: When both units of a pair present fresh tags with no parked tag, the even (lower-indexed) unit's tag is broadcast next cycle. The odd unit's tag is parked, and its hold indicator is set in that same cycle.
- R4: A parked tag is broadcast in the cycle after it was parked and wins over any fresh tag in the pair. A fresh tag that loses this way is parked in its turn.
- R5: A hold indicator clears in the cycle in which its parked tag is on the broadcast lines.
- R6: A tag-producing issue to a unit whose hold indicator is set is ignored. The parked tag is still the one broadcast, and the ignored tag is never broadcast and never parked.
- R7: An issue with iss_wr_tag=0 produces no broadcast and leaves any parked tag and indicator unchanged.
- R8: bc_vld is low in any cycle that follows a cycle with no parked tag and no tag-producing issue in the pair.
- R9: At most one hold indicator per pair is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 2*PAIRS | Per-unit issue strobe |
| iss_wr_tag | input | 2*PAIRS | Per-unit flag: the issuing instruction writes a register tag |
| iss_tag | input | 2*PAIRS*TAG_W | Per-unit destination tag; unit u at bits u*TAG_W and up |
| bc_vld | output | PAIRS | Per-pair broadcast valid (registered) |
| bc_tag | output | PAIRS*TAG_W | Per-pair broadcast tag (registered) |
| hold_ind | output | 2*PAIRS | Per-unit hold indicator to the issue arbiters (registered) |

## Verification
The bench builds the controller with two pairs and 7-bit tags. Each unit in every cycle takes one of three actions: idle, non-tag issue, or tag issue. The bench walks through every pair of consecutive action vectors over all four units, so every parked/fresh/ignored combination is reached from every reachable state in both pairs at once. With two pairs driven by different action digits, the sweep also shows that one pair's parked tag never leaks into the other pair's lines.

// File: rtl/tls_pkg.sv
package tls_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HELD = 2'd1,
    SRC_NEW  = 2'd2
  } bcast_src_e;

endpackage

// File: rtl/tls_slot_hold.sv
module tls_slot_hold #(
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_tag,
  input  logic [TAG_W-1:0] new_tag,
  input  logic             send_held,
  input  logic             park,
  output logic             accept,
  output logic             held,
  output logic [TAG_W-1:0] held_tag
);

  // A fresh tag is accepted only while nothing is parked here.
  assign accept = want_tag & ~held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      held_tag <= '0;
    end else if (held) begin
      if (send_held) held <= 1'b0;
    end else if (park) begin
      held     <= 1'b1;
      held_tag <= new_tag;
    end
  end

endmodule

// File: rtl/tls_pair_pick.sv
module tls_pair_pick
  import tls_pkg::*;
(
  input  logic [1:0] held,
  input  logic [1:0] accept,
  output bcast_src_e src,
  output logic       win,
  output logic [1:0] send_held,
  output logic [1:0] park
);

  always_comb begin
    src = SRC_NONE;
    win = 1'b0;
    if (held[0]) begin
      src = SRC_HELD;
      win = 1'b0;
    end else if (held[1]) begin
      src = SRC_HELD;
      win = 1'b1;
    end else if (accept[0]) begin
      src = SRC_NEW;
      win = 1'b0;
    end else if (accept[1]) begin
      src = SRC_NEW;
      win = 1'b1;
    end
  end

  for (genvar u = 0; u < 2; u++) begin : g_unit
    assign send_held[u] = (src == SRC_HELD) && (win == 1'(u));
    assign park[u]      = accept[u] && !((src == SRC_NEW) && (win == 1'(u)));
  end

endmodule

// File: rtl/tls_pair.sv
module tls_pair
  import tls_pkg::*;
#(
  parameter int TAG_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         want_tag,
  input  logic [2*TAG_W-1:0] new_tag,
  output logic               bc_vld,
  output logic [TAG_W-1:0]   bc_tag,
  output logic [1:0]         held
);

  logic [1:0]       accept;
  logic [1:0]       send_held;
  logic [1:0]       park;
  logic [TAG_W-1:0] held_tag [2];
  bcast_src_e       src;
  logic             win;
  logic [TAG_W-1:0] pick_tag;

  for (genvar u = 0; u < 2; u++) begin : g_slot
    tls_slot_hold #(.TAG_W(TAG_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .want_tag  (want_tag[u]),
      .new_tag   (new_tag[u*TAG_W +: TAG_W]),
      .send_held (send_held[u]),
      .park      (park[u]),
      .accept    (accept[u]),
      .held      (held[u]),
      .held_tag  (held_tag[u])
    );
  end

  tls_pair_pick u_pick (
    .held      (held),
    .accept    (accept),
    .src       (src),
    .win       (win),
    .send_held (send_held),
    .park      (park)
  );

  always_comb begin
    case (src)
      SRC_HELD: pick_tag = held_tag[win];
      SRC_NEW:  pick_tag = win ? new_tag[TAG_W +: TAG_W] : new_tag[0 +: TAG_W];
      default:  pick_tag = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bc_vld <= 1'b0;
      bc_tag <= '0;
    end else begin
      bc_vld <= (src != SRC_NONE);
      bc_tag <= pick_tag;
    end
  end

endmodule

// File: rtl/tagline_share_ctrl.sv
module tagline_share_ctrl #(
  parameter int PAIRS = 3,
  parameter int TAG_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2*PAIRS-1:0]       iss_vld,
  input  logic [2*PAIRS-1:0]       iss_wr_tag,
  input  logic [2*PAIRS*TAG_W-1:0] iss_tag,
  output logic [PAIRS-1:0]         bc_vld,
  output logic [PAIRS*TAG_W-1:0]   bc_tag,
  output logic [2*PAIRS-1:0]       hold_ind
);

  localparam int UNITS = 2 * PAIRS;

  logic [UNITS-1:0] want_tag;
  assign want_tag = iss_vld & iss_wr_tag;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    tls_pair #(.TAG_W(TAG_W)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .want_tag (want_tag[2*p +: 2]),
      .new_tag  (iss_tag[2*p*TAG_W +: 2*TAG_W]),
      .bc_vld   (bc_vld[p]),
      .bc_tag   (bc_tag[p*TAG_W +: TAG_W]),
      .held     (hold_ind[2*p +: 2])
    );
  end

endmodule

// File: rtl/tagline_share_chk.sv
module tagline_share_chk #(
  parameter int PAIRS = 3,
  parameter int TAG_W = 7
) (
  input logic                     clk,
  input logic                     rst,
  input logic [2*PAIRS-1:0]       iss_vld,
  input logic [2*PAIRS-1:0]       iss_wr_tag,
  input logic [2*PAIRS*TAG_W-1:0] iss_tag,
  input logic [PAIRS-1:0]         bc_vld,
  input logic [PAIRS*TAG_W-1:0]   bc_tag,
  input logic [2*PAIRS-1:0]       hold_ind
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (bc_vld == '0) && (hold_ind == '0)); // R1

  for (genvar p = 0; p < PAIRS; p++) begin : g_p
    logic ta, tb, none_held;
    assign ta = iss_vld[2*p]   & iss_wr_tag[2*p];
    assign tb = iss_vld[2*p+1] & iss_wr_tag[2*p+1];
    assign none_held = (hold_ind[2*p +: 2] == 2'b00);

    AST_ONE_HELD: assert property (@(posedge clk) disable iff (rst)
      $countones(hold_ind[2*p +: 2]) <= 1); // R9

    AST_SINGLE_NEW: assert property (@(posedge clk) disable iff (rst)
      (none_held && ta && !tb) |=>
        bc_vld[p] && (bc_tag[p*TAG_W +: TAG_W] == $past(iss_tag[2*p*TAG_W +: TAG_W]))); // R2

    AST_BOTH_NEW: assert property (@(posedge clk) disable iff (rst)
      (none_held && ta && tb) |=>
        bc_vld[p] && hold_ind[2*p+1] &&
        (bc_tag[p*TAG_W +: TAG_W] == $past(iss_tag[2*p*TAG_W +: TAG_W]))); // R3

    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
      (none_held && !ta && !tb) |=> !bc_vld[p]); // R8

    for (genvar u = 0; u < 2; u++) begin : g_u
      AST_HELD_SENT: assert property (@(posedge clk) disable iff (rst)
        hold_ind[2*p+u] |=> bc_vld[p]); // R4

      AST_HELD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hold_ind[2*p+u] |=> !hold_ind[2*p+u]); // R5

      AST_IGNORED_TAG: assert property (@(posedge clk) disable iff (rst)
        (hold_ind[2*p+u] && iss_vld[2*p+u] && iss_wr_tag[2*p+u] &&
         !(iss_vld[2*p+1-u] && iss_wr_tag[2*p+1-u])) |=>
          (hold_ind[2*p +: 2] == 2'b00)); // R6
    end
  end

endmodule

bind tagline_share_ctrl tagline_share_chk #(.PAIRS(PAIRS), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .iss_vld    (iss_vld),
  .iss_wr_tag (iss_wr_tag),
  .iss_tag    (iss_tag),
  .bc_vld     (bc_vld),
  .bc_tag     (bc_tag),
  .hold_ind   (hold_ind)
);

// File: tb/tagline_share_ctrl_test.sv
module tagline_share_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int PAIRS = 2;
  localparam int TAG_W = 7;
  localparam int UNITS = 2 * PAIRS;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [UNITS-1:0]         iss_vld = '0;
  logic [UNITS-1:0]         iss_wr_tag = '0;
  logic [UNITS*TAG_W-1:0]   iss_tag = '0;
  logic [PAIRS-1:0]         bc_vld;
  logic [PAIRS*TAG_W-1:0]   bc_tag;
  logic [UNITS-1:0]         hold_ind;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit    wv [UNITS];
  int    wt [UNITS];
  bit    exp_bv [PAIRS];
  int    exp_bt [PAIRS];
  string lab_b [PAIRS];
  string lab_i [UNITS];
  int    act [UNITS];   // 0 idle, 1 non-tag issue, 2 tag issue
  int    tg  [UNITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tagline_share_ctrl #(.PAIRS(PAIRS), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_wr_tag(iss_wr_tag),
    .iss_tag(iss_tag), .bc_vld(bc_vld), .bc_tag(bc_tag), .hold_ind(hold_ind)
  );

  task automatic check(string lab, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", lab, what, actual, expected);
    end
  endtask

  // Drive act/tg onto the ports and advance the reference by one cycle.
  task automatic step();
    for (int u = 0; u < UNITS; u++) begin
      iss_vld[u]    = (act[u] != 0);
      iss_wr_tag[u] = (act[u] == 2);
      iss_tag[u*TAG_W +: TAG_W] = TAG_W'(tg[u]);
    end
    for (int p = 0; p < PAIRS; p++) begin
      int a = 2*p;
      int b = 2*p + 1;
      bit acc_a = (act[a] == 2) && !wv[a];
      bit acc_b = (act[b] == 2) && !wv[b];
      bit ign   = ((act[a] == 2) && wv[a]) || ((act[b] == 2) && wv[b]);
      int win = -1;
      bit from_held = 0;
      if (wv[a]) begin win = a; from_held = 1; end
      else if (wv[b]) begin win = b; from_held = 1; end
      else if (acc_a) win = a;
      else if (acc_b) win = b;
      exp_bv[p] = (win >= 0);
      exp_bt[p] = (win < 0) ? 0 : (from_held ? wt[win] : tg[win]);
      if (from_held)          lab_b[p] = ign ? "R6" : "R4";
      else if (acc_a && acc_b) lab_b[p] = "R3";
      else if (acc_a || acc_b) lab_b[p] = "R2";
      else if (act[a] == 1 || act[b] == 1) lab_b[p] = "R7";
      else                     lab_b[p] = "R8";
      for (int k = 0; k < 2; k++) begin
        int u = 2*p + k;
        bit acc = k ? acc_b : acc_a;
        if (wv[u] && win == u) begin
          wv[u] = 0; lab_i[u] = "R5";
        end else if (!wv[u] && acc && win != u) begin
          wv[u] = 1; wt[u] = tg[u]; lab_i[u] = from_held ? "R4" : "R3";
        end else if (act[u] == 2 && wv[u]) lab_i[u] = "R6";
        else if (act[u] == 1) lab_i[u] = "R7";
        else lab_i[u] = lab_b[p];
      end
    end
    @(negedge clk);
    for (int p = 0; p < PAIRS; p++) begin
      check(lab_b[p], $sformatf("pair%0d bc_vld", p), int'(bc_vld[p]), int'(exp_bv[p]));
      if (exp_bv[p])
        check(lab_b[p], $sformatf("pair%0d bc_tag", p),
              int'(bc_tag[p*TAG_W +: TAG_W]), exp_bt[p]);
      check("R9", $sformatf("pair%0d held count<=1", p),
            int'($countones(hold_ind[2*p +: 2]) <= 1), 1);
    end
    for (int u = 0; u < UNITS; u++)
      check(lab_i[u], $sformatf("unit%0d hold_ind", u), int'(hold_ind[u]), int'(wv[u]));
  endtask

  initial begin
    for (int u = 0; u < UNITS; u++) begin wv[u] = 0; wt[u] = 0; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "bc_vld after reset", int'(bc_vld), 0);
    check("R1", "hold_ind after reset", int'(hold_ind), 0);
    rst = 1'b0;
    // every pair of consecutive action vectors over all four units
    for (int n = 0; n < 6561; n++) begin
      for (int c = 0; c < 2; c++) begin
        for (int u = 0; u < UNITS; u++) begin
          int div = 1;
          for (int k = 0; k < u + 4*c; k++) div = div * 3;
          act[u] = (n / div) % 3;
          tg[u]  = (n * 5 + u * 37 + c * 11 + 3) % 128;
        end
        step();
      end
    end
    for (int u = 0; u < UNITS; u++) act[u] = 0;
    step();
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule